// File: doc/BRIEF.md
# LIN Commander Header Generator

The block drives the header of a LIN frame onto a UART-style transmit line when it acts as commander. A single command pulse starts a fixed sequence: a dominant break, a recessive gap, the sync byte, a second recessive gap, and then the protected identifier byte, which carries the 6-bit identifier and two parity bits. All timing is counted in bit times. An external baud generator marks the end of each bit time with a one-clock `bit_tick_i` pulse.

Two 2-bit codes, sampled together with the command, set the timing. One code picks the break length. The other code picks both gaps. Both codes index small non-linear tables. While a header is in flight, `busy_o` is high and any further command is dropped. `done_o` pulses once when the identifier's stop bit has finished. The data field, the checksum and all responder-side detection belong to other logic.

Top module: `lin_hdr_gen`

## Requirements
- R1: Break code 0, 1, 2 and 3 holds `tx_o` low for 13, 17, 21 and 26 bit times.
- R2: After the break, `tx_o` stays high for 1, 4, 8 or 14 bit times for gap code 0, 1, 2 or 3. The sync byte starts after this gap.
- R3: After the sync stop bit, `tx_o` stays high for 1 bit time for gap code 0 and 4 bit times for gap codes 1 to 3. The identifier byte starts after this gap.
- R4: A header starts only on a `hdr_start_i` pulse seen while idle. Without a pulse, `tx_o` stays high and `busy_o` stays low whatever `bit_tick_i` does. `busy_o` is high from the clock after an accepted pulse.
- R5: The sync byte is sent as 10 bit times: a low start bit, then 0x55 LSB first, then a high stop bit.
- R6: The identifier byte is sent as 10 bit times, framed like the sync byte and LSB first. Bits 5:0 are the identifier. Bit 6 is ID0^ID1^ID2^ID4. Bit 7 is the inverse of ID1^ID3^ID4^ID5.
- R7: A `hdr_start_i` pulse while `busy_o` is high is ignored. The running header keeps the identifier and codes latched at its own start.
- R8: `done_o` is high for exactly one clock, following the tick that ends the identifier stop bit. `busy_o` falls on the same edge.
- R9: While `rst_ni` is low, `tx_o` is 1, `busy_o` is 0 and `done_o` is 0. A reset in the middle of a header abandons it.
- R10: `tx_o` changes only on the clock edge that consumes a `bit_tick_i` pulse, or on the edge that accepts a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-clock pulse that ends each bit time |
| hdr_start_i | input | 1 | Header command pulse |
| hdr_id_i | input | 6 | Frame identifier |
| brk_sel_i | input | 2 | Break length code |
| gap_sel_i | input | 2 | Gap code for both delays |
| tx_o | output | 1 | Serial line, high is recessive |
| busy_o | output | 1 | Header in progress |
| done_o | output | 1 | One-clock pulse when the header ends |

## Verification
The assertions assume that a command pulse is never issued in the same clock as `bit_tick_i`. They also assume that `bit_tick_i` is a single-cycle pulse, so a bit time never lasts less than one clock. The stimulus spaces each tick three clocks apart. It places every command and every ignored command pulse in a clock with no tick. The ignored pulses also carry a different identifier and different codes, so a failure to latch would show up at `tx_o`.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
  localparam int ID_W    = 6;
  localparam int SEL_W   = 2;
  localparam int LEN_W   = 5;   // holds the longest field, 26
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = BYTE_W + 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BREAK,
    ST_GAP1,
    ST_SYNC,
    ST_GAP2,
    ST_PID
  } phase_e;
endpackage

// File: rtl/lin_hdr_timing.sv
module lin_hdr_timing
  import lin_hdr_pkg::*;
(
  input  logic [SEL_W-1:0] brk_sel_i,
  input  logic [SEL_W-1:0] gap_sel_i,
  output logic [LEN_W-1:0] brk_len_o,
  output logic [LEN_W-1:0] gap1_len_o,
  output logic [LEN_W-1:0] gap2_len_o
);
  always_comb begin
    unique case (brk_sel_i)
      2'd0:    brk_len_o = LEN_W'(13);
      2'd1:    brk_len_o = LEN_W'(17);
      2'd2:    brk_len_o = LEN_W'(21);
      default: brk_len_o = LEN_W'(26);
    endcase
  end

  always_comb begin
    unique case (gap_sel_i)
      2'd0:    gap1_len_o = LEN_W'(1);
      2'd1:    gap1_len_o = LEN_W'(4);
      2'd2:    gap1_len_o = LEN_W'(8);
      default: gap1_len_o = LEN_W'(14);
    endcase
    gap2_len_o = (gap_sel_i == '0) ? LEN_W'(1) : LEN_W'(4);
  end
endmodule

// File: rtl/lin_hdr_pid.sv
module lin_hdr_pid
  import lin_hdr_pkg::*;
(
  input  logic [ID_W-1:0]   id_i,
  output logic [BYTE_W-1:0] pid_o
);
  logic par_lo, par_hi;

  always_comb begin
    par_lo = id_i[0] ^ id_i[1] ^ id_i[2] ^ id_i[4];
    par_hi = ~(id_i[1] ^ id_i[3] ^ id_i[4] ^ id_i[5]);
    pid_o  = {par_hi, par_lo, id_i};
  end
endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
  import lin_hdr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SYNC_BYTE = 8'h55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_tick_i,
  input  logic              start_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [SEL_W-1:0]  brk_sel_i,
  input  logic [SEL_W-1:0]  gap_sel_i,
  input  logic [LEN_W-1:0]  brk_len_i,
  input  logic [LEN_W-1:0]  gap1_len_i,
  input  logic [LEN_W-1:0]  gap2_len_i,
  input  logic [BYTE_W-1:0] pid_i,
  output logic [ID_W-1:0]   id_q_o,
  output logic [SEL_W-1:0]  brk_sel_q_o,
  output logic [SEL_W-1:0]  gap_sel_q_o,
  output logic              tx_o,
  output logic              busy_o,
  output logic              done_o
);
  phase_e             state_q, state_d;
  logic [LEN_W-1:0]   cnt_q;
  logic [LEN_W-1:0]   phase_len;
  logic [FRAME_W-1:0] sh_q;
  logic               last_bit;

  always_comb begin
    unique case (state_q)
      ST_BREAK:        phase_len = brk_len_i;
      ST_GAP1:         phase_len = gap1_len_i;
      ST_GAP2:         phase_len = gap2_len_i;
      ST_SYNC, ST_PID: phase_len = LEN_W'(FRAME_W);
      default:         phase_len = LEN_W'(1);
    endcase
  end

  assign last_bit = (cnt_q == phase_len - LEN_W'(1));

  always_comb begin
    unique case (state_q)
      ST_BREAK: state_d = ST_GAP1;
      ST_GAP1:  state_d = ST_SYNC;
      ST_SYNC:  state_d = ST_GAP2;
      ST_GAP2:  state_d = ST_PID;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      sh_q        <= '1;
      id_q_o      <= '0;
      brk_sel_q_o <= '0;
      gap_sel_q_o <= '0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          id_q_o      <= id_i;
          brk_sel_q_o <= brk_sel_i;
          gap_sel_q_o <= gap_sel_i;
          cnt_q       <= '0;
          state_q     <= ST_BREAK;
        end
      end else if (bit_tick_i) begin
        if (last_bit) begin
          cnt_q   <= '0;
          state_q <= state_d;
          unique case (state_q)
            ST_GAP1: sh_q <= {1'b1, SYNC_BYTE, 1'b0};
            ST_GAP2: sh_q <= {1'b1, pid_i, 1'b0};
            ST_PID:  begin sh_q <= '1; done_o <= 1'b1; end
            default: sh_q <= '1;
          endcase
        end else begin
          cnt_q <= cnt_q + LEN_W'(1);
          if (state_q == ST_SYNC || state_q == ST_PID)
            sh_q <= {1'b1, sh_q[FRAME_W-1:1]};
        end
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_BREAK:        tx_o = 1'b0;
      ST_SYNC, ST_PID: tx_o = sh_q[0];
      default:         tx_o = 1'b1;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);

  // counter never runs past the decoded field length
  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q < phase_len));

  p_start_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  p_cfg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(id_q_o) && $stable(brk_sel_q_o) && $stable(gap_sel_q_o)));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(state_q) == ST_PID && $past(bit_tick_i) && !busy_o));

  p_tx_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$past(bit_tick_i)) |-> $stable(tx_o));
endmodule

// File: rtl/lin_hdr_gen.sv
module lin_hdr_gen
  import lin_hdr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_tick_i,
  input  logic       hdr_start_i,
  input  logic [5:0] hdr_id_i,
  input  logic [1:0] brk_sel_i,
  input  logic [1:0] gap_sel_i,
  output logic       tx_o,
  output logic       busy_o,
  output logic       done_o
);
  logic [ID_W-1:0]   id_q;
  logic [SEL_W-1:0]  brk_sel_q, gap_sel_q;
  logic [LEN_W-1:0]  brk_len, gap1_len, gap2_len;
  logic [BYTE_W-1:0] pid;

  lin_hdr_timing i_timing (
    .brk_sel_i  (brk_sel_q),
    .gap_sel_i  (gap_sel_q),
    .brk_len_o  (brk_len),
    .gap1_len_o (gap1_len),
    .gap2_len_o (gap2_len)
  );

  lin_hdr_pid i_pid (
    .id_i  (id_q),
    .pid_o (pid)
  );

  lin_hdr_seq i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_tick_i  (bit_tick_i),
    .start_i     (hdr_start_i),
    .id_i        (hdr_id_i),
    .brk_sel_i   (brk_sel_i),
    .gap_sel_i   (gap_sel_i),
    .brk_len_i   (brk_len),
    .gap1_len_i  (gap1_len),
    .gap2_len_i  (gap2_len),
    .pid_i       (pid),
    .id_q_o      (id_q),
    .brk_sel_q_o (brk_sel_q),
    .gap_sel_q_o (gap_sel_q),
    .tx_o        (tx_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  p_idle_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);
endmodule

// File: tb/test_lin_hdr_gen.sv
module test_lin_hdr_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       start = 1'b0;
  logic [5:0] id = '0;
  logic [1:0] brk = '0;
  logic [1:0] gap = '0;
  logic       tx, busy, done;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  lin_hdr_gen i_lin_hdr_gen (
    .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .hdr_start_i(start),
    .hdr_id_i(id), .brk_sel_i(brk), .gap_sel_i(gap),
    .tx_o(tx), .busy_o(busy), .done_o(done)
  );

  // {ignored-pulse flag, break code, gap code, id}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 2'd0, 2'd0, 6'h00},
    {1'b0, 2'd1, 2'd1, 6'h3F},
    {1'b0, 2'd2, 2'd2, 6'h2A},
    {1'b0, 2'd3, 2'd3, 6'h15},
    {1'b1, 2'd0, 2'd3, 6'h01},
    {1'b0, 2'd3, 2'd0, 6'h3C},
    {1'b1, 2'd2, 2'd1, 6'h12},
    {1'b0, 2'd1, 2'd2, 6'h07}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  function automatic int brk_bits(input logic [1:0] c);
    case (c) 2'd0: return 13; 2'd1: return 17; 2'd2: return 21; default: return 26; endcase
  endfunction
  function automatic int gap1_bits(input logic [1:0] c);
    case (c) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction
  function automatic int gap2_bits(input logic [1:0] c);
    return (c == 2'd0) ? 1 : 4;
  endfunction

  task automatic run_hdr(input logic [5:0] hid, input logic [1:0] b, input logic [1:0] g, input bit ign);
    logic [63:0] exp_s = '1;
    logic [63:0] got_s = '1;
    logic [7:0]  pid;
    int seg_err [5] = '{0, 0, 0, 0, 0};
    int nb = brk_bits(b), n1 = gap1_bits(g), n2 = gap2_bits(g);
    int o1 = nb, os = nb + n1, o2 = os + 10, op = o2 + n2, total = op + 10;
    int hold_err = 0;
    logic s0, s1;
    pid = {~(hid[1] ^ hid[3] ^ hid[4] ^ hid[5]), hid[0] ^ hid[1] ^ hid[2] ^ hid[4], hid};
    for (int k = 0; k < total; k++) begin
      if (k < o1)      exp_s[k] = 1'b0;
      else if (k < os) exp_s[k] = 1'b1;
      else if (k < o2) exp_s[k] = (k == os) ? 1'b0 : (k == o2 - 1) ? 1'b1 : 8'h55 >> (k - os - 1);
      else if (k < op) exp_s[k] = 1'b1;
      else             exp_s[k] = (k == op) ? 1'b0 : (k == total - 1) ? 1'b1 : pid >> (k - op - 1);
    end
    @(negedge clk); start = 1'b1; id = hid; brk = b; gap = g;
    @(negedge clk); start = 1'b0; id = ~hid; brk = ~b; gap = ~g;
    check(busy === 1'b1, "R4 busy after command", {63'd0, busy}, 64'd1);
    for (int k = 0; k < total; k++) begin
      if (k != 0) @(negedge clk);
      tick = 1'b0;
      s0 = tx;
      if (ign && k == 5) start = 1'b1;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      s1 = tx;
      if (s0 !== s1) hold_err++;
      got_s[k] = s1;
      if (s1 !== exp_s[k]) begin
        if (k < o1) seg_err[0]++; else if (k < os) seg_err[1]++; else if (k < o2) seg_err[2]++;
        else if (k < op) seg_err[3]++; else seg_err[4]++;
      end
      tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
    check(done === 1'b1 && busy === 1'b0, "R8 done at end", {62'd0, done, busy}, 64'd2);
    @(negedge clk);
    check(done === 1'b0, "R8 done one clock", {63'd0, done}, 64'd0);
    check(seg_err[0] == 0, "R1 break length", got_s, exp_s);
    check(seg_err[1] == 0, "R2 first gap", got_s, exp_s);
    check(seg_err[2] == 0, "R5 sync frame", got_s, exp_s);
    check(seg_err[3] == 0, "R3 second gap", got_s, exp_s);
    check(seg_err[4] == 0, ign ? "R7 ignored command / R6 pid" : "R6 pid frame", got_s, exp_s);
    check(hold_err == 0, "R10 tx stable between ticks", 64'(hold_err), 64'd0);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #1;
    check(tx === 1'b1 && busy === 1'b0 && done === 1'b0, "R9 reset state", {61'd0, tx, busy, done}, 64'd4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // ticks without a command
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); tick = ~tick;
      if (tx !== 1'b1 || busy !== 1'b0) begin
        check(1'b0, "R4 idle without command", {62'd0, tx, busy}, 64'd2);
        break;
      end
    end
    @(negedge clk); tick = 1'b0;
    check(tx === 1'b1 && busy === 1'b0, "R4 idle without command", {62'd0, tx, busy}, 64'd2);
    for (int v = 0; v < 8; v++)
      run_hdr(VEC[v][5:0], VEC[v][9:8], VEC[v][7:6], VEC[v][10]);
    // reset in the middle of a header
    @(negedge clk); start = 1'b1; id = 6'h0A; brk = 2'd2; gap = 2'd1;
    @(negedge clk); start = 1'b0;
    repeat (6) begin @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0; end
    check(tx === 1'b0 && busy === 1'b1, "R1 break in progress", {62'd0, tx, busy}, 64'd1);
    rst_n = 1'b0; #1;
    check(tx === 1'b1 && busy === 1'b0 && done === 1'b0, "R9 reset mid header", {61'd0, tx, busy, done}, 64'd4);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) begin @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0; end
    check(tx === 1'b1 && busy === 1'b0, "R9 stays idle after reset", {62'd0, tx, busy}, 64'd2);
    run_hdr(6'h2D, 2'd3, 2'd2, 1'b1);
    finished = 1'b1;
    report();
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      check(1'b0, "watchdog expired", 64'd0, 64'd1);
      report();
    end
  end
endmodule